// File: doc/BRIEF.md
# Sixteen-Bit Square-Root Carry-Select Adder with Shared Candidate Logic

This block adds two 16-bit operands and a carry-in with no clock, producing a 16-bit sum and a carry-out. The operand is cut into five slices that widen towards the most significant end. The lowest slice is a plain ripple chain fed by the external carry-in. Every higher slice works out two answers ahead of time, one for an incoming carry of zero and one for an incoming carry of one. The carry leaving the slice below then picks one of them, so the long carry path passes through a single multiplexer per slice rather than rippling through every bit.

Both candidates in a slice come from one set of per-bit terms: the XOR, AND and OR of the two operand bits. The zero candidate takes the XOR as its sum bit and the AND as its carry. The one candidate takes the inverted XOR as its sum bit and the OR as its carry. Higher bits in each chain ripple from these terms. There is no second ripple adder and no increment circuit. The block is meant to serve as the final adder that merges the sum and carry vectors of a multiply-accumulate datapath.

Top module: `sqcsa_adder`

## Requirements
- R1: `{carryOut, sumOut}` equals `opA + opB + carryIn` for every operand value. The arithmetic is unsigned and 17 bits wide.
- R2: From bit 0 upwards the slices are 2, 2, 3, 4 and 5 bits wide, so they start at bits 0, 2, 4, 7 and 11. A carry made in the top bit of any slice reaches the lowest bit of the next slice.
- R3: Only the lowest slice sees `carryIn`. With both operands zero, `carryIn` = 1 gives a sum of 1 and `carryOut` = 0.
- R4: In each upper slice, the carry-in-one candidate (sum bits plus slice carry) equals the carry-in-zero candidate plus one.
- R5: Each upper slice outputs its carry-in-one candidate when the slice below carries out, and its carry-in-zero candidate when it does not.
- R6: When every bit propagates (`opA` = 16'hFFFF, `opB` = 0), `carryIn` = 1 gives sum 0 with `carryOut` = 1, and `carryIn` = 0 gives 16'hFFFF with `carryOut` = 0.
- R7: `carryOut` is the seventeenth bit of the total. Two operands of 16'hFFFF with `carryIn` = 1 give 16'hFFFF with `carryOut` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First addend |
| opB | input | 16 | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Low 16 bits of the total |
| carryOut | output | 1 | Carry out of bit 15 |

## Verification
A wrong candidate or a wrong select shows up in the same evaluation as a sum that is off by a power of two at the lowest bit of the affected slice. It often comes with a wrong `carryOut` as well. The select fault appears only when the carry into that slice takes the value that picks the bad path, so the stimulus places a carry at the top bit of every slice. It also includes vectors where the whole word propagates. A slice boundary placed at the wrong bit shows as wrong sums only in those edge patterns, so each boundary has its own vector.

// File: rtl/sqcsa_pkg.sv
package sqcsa_pkg;

  // width of slice idx: base width for the two lowest, then one wider each step
  function automatic int groupWidth(input int idx, input int baseW);
    return (idx == 0) ? baseW : baseW + idx - 1;
  endfunction

  // lowest bit position of slice idx
  function automatic int groupLsb(input int idx, input int baseW);
    int pos;
    pos = 0;
    for (int k = 0; k < idx; k++) pos += groupWidth(k, baseW);
    return pos;
  endfunction

  // total bits covered by numGroups slices
  function automatic int totalWidth(input int numGroups, input int baseW);
    return groupLsb(numGroups, baseW);
  endfunction

endpackage

// File: rtl/sqcsa_ripple_group.sv
module sqcsa_ripple_group #(
  parameter int W = 2
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         cIn,
  output logic [W-1:0] sumOut,
  output logic         cOut
);

  logic [W-1:0] xorTerm;
  logic [W-1:0] andTerm;

  assign xorTerm = aIn ^ bIn;
  assign andTerm = aIn & bIn;

  always_comb begin
    logic carry;
    carry = cIn;
    for (int i = 0; i < W; i++) begin
      sumOut[i] = xorTerm[i] ^ carry;
      carry     = andTerm[i] | (xorTerm[i] & carry);
    end
    cOut = carry;
  end

  // R3
  always_comb begin
    low_slice_sum_chk: assert ({cOut, sumOut} == ({1'b0, aIn} + {1'b0, bIn} + {{W{1'b0}}, cIn}))
      else $error("low slice total wrong");
  end

endmodule

// File: rtl/sqcsa_dual_group.sv
module sqcsa_dual_group #(
  parameter int W = 3
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         selIn,
  output logic [W-1:0] sumOut,
  output logic         cOut
);

  // shared per-bit terms feeding both candidate chains
  logic [W-1:0] xorTerm;
  logic [W-1:0] andTerm;
  logic [W-1:0] orTerm;

  assign xorTerm = aIn ^ bIn;
  assign andTerm = aIn & bIn;
  assign orTerm  = aIn | bIn;

  logic [W-1:0] zeroSum;
  logic         zeroCarry;
  logic [W-1:0] oneSum;
  logic         oneCarry;

  // carry-in zero chain: first bit is XOR / AND
  always_comb begin
    logic carry;
    zeroSum[0] = xorTerm[0];
    carry      = andTerm[0];
    for (int i = 1; i < W; i++) begin
      zeroSum[i] = xorTerm[i] ^ carry;
      carry      = andTerm[i] | (xorTerm[i] & carry);
    end
    zeroCarry = carry;
  end

  // carry-in one chain: first bit is inverted XOR / OR
  always_comb begin
    logic carry;
    oneSum[0] = ~xorTerm[0];
    carry     = orTerm[0];
    for (int i = 1; i < W; i++) begin
      oneSum[i] = xorTerm[i] ^ carry;
      carry     = andTerm[i] | (xorTerm[i] & carry);
    end
    oneCarry = carry;
  end

  assign {cOut, sumOut} = selIn ? {oneCarry, oneSum} : {zeroCarry, zeroSum};

  // R4
  always_comb begin
    cand_step_chk: assert ({oneCarry, oneSum} == ({zeroCarry, zeroSum} + 1'b1))
      else $error("carry-one candidate is not zero candidate plus one");
  end

  // R5
  always_comb begin
    slice_total_chk: assert ({cOut, sumOut} == ({1'b0, aIn} + {1'b0, bIn} + {{W{1'b0}}, selIn}))
      else $error("slice output does not follow selected carry");
  end

  // R6
  always_comb begin
    if (&xorTerm) begin
      full_prop_chk: assert (oneCarry && !zeroCarry)
        else $error("propagating slice carries wrong");
    end
  end

endmodule

// File: rtl/sqcsa_adder.sv
module sqcsa_adder #(
  parameter int WIDTH      = 16,
  parameter int NUM_GROUPS = 5,
  parameter int BASE_W     = 2
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  import sqcsa_pkg::*;

  localparam int COVERED = totalWidth(NUM_GROUPS, BASE_W);

  initial begin
    // R2
    cover_width_chk: assert (COVERED == WIDTH)
      else $error("slice widths do not cover the operand");
  end

  logic groupCarry [NUM_GROUPS+1];

  assign groupCarry[0] = carryIn;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gSlice
    localparam int GW  = groupWidth(g, BASE_W);
    localparam int LSB = groupLsb(g, BASE_W);
    if (g == 0) begin : gLow
      sqcsa_ripple_group #(.W(GW)) lowSlice (
        .aIn   (opA[LSB +: GW]),
        .bIn   (opB[LSB +: GW]),
        .cIn   (groupCarry[g]),
        .sumOut(sumOut[LSB +: GW]),
        .cOut  (groupCarry[g+1])
      );
    end else begin : gHigh
      sqcsa_dual_group #(.W(GW)) dualSlice (
        .aIn   (opA[LSB +: GW]),
        .bIn   (opB[LSB +: GW]),
        .selIn (groupCarry[g]),
        .sumOut(sumOut[LSB +: GW]),
        .cOut  (groupCarry[g+1])
      );
    end
  end

  assign carryOut = groupCarry[NUM_GROUPS];

  // R1
  always_comb begin
    total_sum_chk: assert ({carryOut, sumOut} ==
                           ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}))
      else $error("adder total wrong");
  end

endmodule

// File: tb/sqcsa_adder_test.sv
module sqcsa_adder_test;

  localparam int W = 16;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sqcsa_adder uut (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  // {opA, opB, carryIn}; expected computed as the 17-bit total (R1)
  localparam logic [32:0] VEC [NVEC] = '{
    {16'h0003, 16'h0001, 1'b0},  // R2 carry out of slice 0
    {16'h000C, 16'h0004, 1'b0},  // R2 carry out of slice 1
    {16'h0070, 16'h0010, 1'b0},  // R2 carry out of slice 2
    {16'h0780, 16'h0080, 1'b0},  // R2 carry out of slice 3
    {16'hF800, 16'h0800, 1'b0},  // R2 carry out of slice 4
    {16'h0002, 16'h0001, 1'b1},  // R5 carry from cin into slice 1
    {16'h0005, 16'h0002, 1'b1},  // R5 ripple through two slices
    {16'h1234, 16'h4321, 1'b0},
    {16'hABCD, 16'h5432, 1'b1},
    {16'h8000, 16'h8000, 1'b0},  // R7
    {16'h5555, 16'hAAAA, 1'b0},
    {16'h5555, 16'hAAAA, 1'b1},  // R6 full propagate
    {16'h007F, 16'h0001, 1'b0},  // R5
    {16'h0FFF, 16'h0001, 1'b0}   // R5
  };

  task automatic applyCheck(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic c, input string req);
    logic [W:0] expv;
    @(posedge clk);
    opA = a; opB = b; carryIn = c;
    expv = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    @(negedge clk);
    checks++;
    if ({carryOut, sumOut} !== expv) begin
      errors++;
      $display("FAIL %s a=%h b=%h c=%b actual=%h expected=%h",
               req, a, b, c, {carryOut, sumOut}, expv);
    end
  endtask

  initial begin
    logic [W-1:0] lfA;
    logic [W-1:0] lfB;
    // idle state with zero inputs (R1)
    @(negedge clk);
    checks++;
    if ({carryOut, sumOut} !== 17'h0) begin
      errors++;
      $display("FAIL R1 idle actual=%h expected=%h", {carryOut, sumOut}, 17'h0);
    end

    for (int i = 0; i < NVEC; i++)
      applyCheck(VEC[i][32:17], VEC[i][16:1], VEC[i][0], "R1/R2/R5 vector");

    applyCheck(16'h0000, 16'h0000, 1'b1, "R3");
    applyCheck(16'hFFFF, 16'h0000, 1'b1, "R6");
    applyCheck(16'hFFFF, 16'h0000, 1'b0, "R6");
    applyCheck(16'h0000, 16'hFFFF, 1'b1, "R6");
    applyCheck(16'hFFFF, 16'hFFFF, 1'b1, "R7");
    applyCheck(16'hFFFF, 16'hFFFF, 1'b0, "R7");

    // R4: a carry entering each upper slice must add exactly one there
    for (int s = 0; s < 4; s++) begin
      int lsbs [4] = '{2, 4, 7, 11};
      logic [W-1:0] below;
      below = (16'h1 << lsbs[s]) - 1'b1;
      applyCheck(below, 16'h0001, 1'b0, "R4");
      applyCheck(below | (16'h3 << lsbs[s]), 16'h0000, 1'b1, "R4");
    end

    lfA = 16'hACE1;
    lfB = 16'h1D0F;
    for (int i = 0; i < 300; i++) begin
      lfA = {lfA[14:0], lfA[15] ^ lfA[13] ^ lfA[12] ^ lfA[10]};
      lfB = {lfB[14:0], lfB[15] ^ lfB[14] ^ lfB[12] ^ lfB[3]};
      applyCheck(lfA, lfB, lfA[0] ^ lfB[5], "R1");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule